// File: doc/BRIEF.md
# Scratch-Register Spill and Fill Inserter

This pipeline stage sits in a binary-translation datapath and works on decoded instruction records. The target code borrows a small set of reserved registers as temporaries. The source program may still hold live values in those registers, so the stage wraps any instruction that touches one of them. It first loads the program's value back from a scratch-pad memory. It then issues the instruction itself. If the instruction writes a reserved register, it finally stores that register back to the scratch pad.

Every scratch-pad access uses one dedicated base register plus a fixed byte offset for each reserved register. Slot i (counted from 0) sits at offset 4·(i+1). The base register and the reserved registers come from configuration inputs; typical values are base 27 and slots 24, 25 and 26. While the stage is emitting the extra records for one instruction, it holds off the stage upstream of it.

Top module: `spill_fill_inserter`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and cfg_err is 0 when the configuration is valid.
- R2: Before the operation, one load record (out_kind = 1) is emitted for each slot whose register is read by an enabled source operand. Each load has rd = slot register with rd_we = 1, rs1 = base with rs1_en = 1, rs2_en = 0 and imm = 4·(slot+1). The loads come in ascending slot order. A slot read by both operands gets only one load.
- R3: The instruction itself is emitted as an operation record (out_kind = 0), with op, rd, rd_we, rs1, rs1_en, rs2, rs2_en and imm copied unchanged. It comes after all loads for that instruction.
- R4: When the instruction writes (rd_we = 1) a slot register, a single store record (out_kind = 2) follows the operation. The store has rs1 = base, rs2 = slot register, both enables set, rd_we = 0 and imm = 4·(slot+1).
- R5: An instruction that touches no slot register yields exactly one output record. Such instructions are accepted back to back, one per cycle, while out_ready is high.
- R6: While out_valid is high and out_ready is low, every output field holds its value.
- R7: in_ready is low while records for an already accepted instruction remain to be emitted.
- R8: cfg_err goes to 1 one cycle after the configuration has the base equal to any slot register, or two slot registers equal. While the configuration is invalid, every instruction passes through as a single unchanged operation record.
- R9: A source operand whose enable is 0 causes no load, and an rd with rd_we = 0 causes no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_reg | input | REGW | Scratch base register number |
| cfg_slot_regs | input | NSLOT*REGW | Reserved register numbers, slot 0 in the low bits |
| cfg_err | output | 1 | Registered invalid-configuration flag |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Stage can take an input record |
| in_op | input | OPW | Operation code |
| in_rd | input | REGW | Destination register |
| in_rd_we | input | 1 | Destination is written |
| in_rs1 | input | REGW | First source register |
| in_rs1_en | input | 1 | First source is read |
| in_rs2 | input | REGW | Second source register |
| in_rs2_en | input | 1 | Second source is read |
| in_imm | input | IMMW | Immediate |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream accepts the record |
| out_kind | output | 2 | 0 operation, 1 load, 2 store |
| out_op | output | OPW | Operation code (0 for load and store) |
| out_rd | output | REGW | Destination register |
| out_rd_we | output | 1 | Destination is written |
| out_rs1 | output | REGW | First source / address base |
| out_rs1_en | output | 1 | First source is read |
| out_rs2 | output | REGW | Second source / store data |
| out_rs2_en | output | 1 | Second source is read |
| out_imm | output | IMMW | Immediate or scratch-pad offset |

## Verification
The hardest case to reach from the ports is a stall while the stage is in the middle of an expansion. This happens when downstream backpressure arrives while loads, the operation and a store are still queued for one accepted instruction. To reach it, the bench drops out_ready before offering a three-slot instruction and keeps it low for several cycles with the first load on the output. It then releases out_ready and checks the rest of the sequence and the timing of in_ready. Two other cases also need stimulus set up on purpose. One is load ordering when the operands name slots in descending order. The other is the switch to pass-through after the configuration becomes invalid.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  typedef enum logic [1:0] {
    K_OP    = 2'd0,
    K_LOAD  = 2'd1,
    K_STORE = 2'd2
  } sfi_kind_e;
endpackage

// File: rtl/sfi_cfg_check.sv
module sfi_cfg_check #(
  parameter int NSLOT = 3,
  parameter int REGW  = 5
) (
  input  logic [REGW-1:0]       base_reg,
  input  logic [NSLOT*REGW-1:0] slot_regs,
  output logic                  bad
);
  logic [NSLOT-1:0] hit_base;
  logic [NSLOT-1:0] hit_dup;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign hit_base[i] = (slot_regs[i*REGW +: REGW] == base_reg);
    if (i == 0) begin : g_first
      assign hit_dup[i] = 1'b0;
    end else begin : g_rest
      logic [i-1:0] eq;
      for (genvar j = 0; j < i; j++) begin : g_pair
        assign eq[j] = (slot_regs[i*REGW +: REGW] == slot_regs[j*REGW +: REGW]);
      end
      assign hit_dup[i] = |eq;
    end
  end

  assign bad = (|hit_base) | (|hit_dup);
endmodule

// File: rtl/sfi_slot_match.sv
module sfi_slot_match #(
  parameter int NSLOT = 3,
  parameter int REGW  = 5
) (
  input  logic [NSLOT*REGW-1:0] slot_regs,
  input  logic                  block,
  input  logic [REGW-1:0]       rd,
  input  logic                  rd_we,
  input  logic [REGW-1:0]       rs1,
  input  logic                  rs1_en,
  input  logic [REGW-1:0]       rs2,
  input  logic                  rs2_en,
  output logic [NSLOT-1:0]      fill_mask,
  output logic [NSLOT-1:0]      spill_mask
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [REGW-1:0] sr;
    assign sr            = slot_regs[i*REGW +: REGW];
    assign fill_mask[i]  = !block && ((rs1_en && rs1 == sr) || (rs2_en && rs2 == sr));
    assign spill_mask[i] = !block && rd_we && (rd == sr);
  end
endmodule

// File: rtl/spill_fill_inserter.sv
module spill_fill_inserter #(
  parameter int NSLOT      = 3,
  parameter int REGW       = 5,
  parameter int OPW        = 6,
  parameter int IMMW       = 32,
  parameter int SLOT_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REGW-1:0]       cfg_base_reg,
  input  logic [NSLOT*REGW-1:0] cfg_slot_regs,
  output logic                  cfg_err,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [OPW-1:0]        in_op,
  input  logic [REGW-1:0]       in_rd,
  input  logic                  in_rd_we,
  input  logic [REGW-1:0]       in_rs1,
  input  logic                  in_rs1_en,
  input  logic [REGW-1:0]       in_rs2,
  input  logic                  in_rs2_en,
  input  logic [IMMW-1:0]       in_imm,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [1:0]            out_kind,
  output logic [OPW-1:0]        out_op,
  output logic [REGW-1:0]       out_rd,
  output logic                  out_rd_we,
  output logic [REGW-1:0]       out_rs1,
  output logic                  out_rs1_en,
  output logic [REGW-1:0]       out_rs2,
  output logic                  out_rs2_en,
  output logic [IMMW-1:0]       out_imm
);
  import sfi_pkg::*;

  localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic             err_c;
  logic [NSLOT-1:0] nf, ns;
  logic [NSLOT-1:0] p_fill, p_spill;
  logic             p_op;
  logic             pend_any;

  logic [OPW-1:0]  h_op;
  logic [REGW-1:0] h_rd, h_rs1, h_rs2;
  logic            h_rd_we, h_rs1_en, h_rs2_en;
  logic [IMMW-1:0] h_imm;

  sfi_cfg_check #(.NSLOT(NSLOT), .REGW(REGW)) u_cfg (
    .base_reg (cfg_base_reg),
    .slot_regs(cfg_slot_regs),
    .bad      (err_c)
  );

  sfi_slot_match #(.NSLOT(NSLOT), .REGW(REGW)) u_match (
    .slot_regs (cfg_slot_regs),
    .block     (err_c),
    .rd        (in_rd),
    .rd_we     (in_rd_we),
    .rs1       (in_rs1),
    .rs1_en    (in_rs1_en),
    .rs2       (in_rs2),
    .rs2_en    (in_rs2_en),
    .fill_mask (nf),
    .spill_mask(ns)
  );

  assign pend_any = (|p_fill) | p_op | (|p_spill);
  assign in_ready = (!out_valid || out_ready) && !pend_any;

  logic advance;
  assign advance = (!out_valid || out_ready) && (pend_any || in_valid);

  // source of the next record: held instruction or the incoming one
  logic [NSLOT-1:0] s_fill, s_spill;
  logic             s_op;
  logic [OPW-1:0]   s_op_code;
  logic [REGW-1:0]  s_rd, s_rs1, s_rs2;
  logic             s_rd_we, s_rs1_en, s_rs2_en;
  logic [IMMW-1:0]  s_imm;

  always_comb begin
    if (pend_any) begin
      s_fill = p_fill;  s_op = p_op;  s_spill = p_spill;
      s_op_code = h_op; s_rd = h_rd; s_rd_we = h_rd_we;
      s_rs1 = h_rs1; s_rs1_en = h_rs1_en; s_rs2 = h_rs2; s_rs2_en = h_rs2_en;
      s_imm = h_imm;
    end else begin
      s_fill = nf;  s_op = 1'b1;  s_spill = ns;
      s_op_code = in_op; s_rd = in_rd; s_rd_we = in_rd_we;
      s_rs1 = in_rs1; s_rs1_en = in_rs1_en; s_rs2 = in_rs2; s_rs2_en = in_rs2_en;
      s_imm = in_imm;
    end
  end

  // pick the next record: lowest fill, then op, then spill
  sfi_kind_e        n_kind;
  logic [IDXW-1:0]  fidx, sidx, pidx;
  logic [NSLOT-1:0] r_fill, r_spill;
  logic             r_op;
  logic [REGW-1:0]  pick_reg;
  logic [IMMW-1:0]  pick_off;

  always_comb begin
    fidx = '0;
    sidx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (s_fill[i])  fidx = IDXW'(i);
      if (s_spill[i]) sidx = IDXW'(i);
    end
    r_fill  = s_fill;
    r_spill = s_spill;
    r_op    = s_op;
    pidx    = fidx;
    if (|s_fill) begin
      n_kind = K_LOAD;
      r_fill[fidx] = 1'b0;
    end else if (s_op) begin
      n_kind = K_OP;
      r_op   = 1'b0;
    end else begin
      n_kind = K_STORE;
      pidx   = sidx;
      r_spill[sidx] = 1'b0;
    end
    pick_reg = cfg_slot_regs[32'(pidx)*REGW +: REGW];
    pick_off = IMMW'((32'(pidx) + 32'd1) * 32'(SLOT_BYTES));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err   <= 1'b0;
      out_valid <= 1'b0;
      p_fill    <= '0;
      p_spill   <= '0;
      p_op      <= 1'b0;
    end else begin
      cfg_err <= err_c;
      if (advance) begin
        out_valid <= 1'b1;
        p_fill    <= r_fill;
        p_spill   <= r_spill;
        p_op      <= r_op;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      h_op <= s_op_code; h_rd <= s_rd; h_rd_we <= s_rd_we;
      h_rs1 <= s_rs1; h_rs1_en <= s_rs1_en; h_rs2 <= s_rs2; h_rs2_en <= s_rs2_en;
      h_imm <= s_imm;
      out_kind <= n_kind;
      unique case (n_kind)
        K_LOAD: begin
          out_op <= '0; out_rd <= pick_reg; out_rd_we <= 1'b1;
          out_rs1 <= cfg_base_reg; out_rs1_en <= 1'b1;
          out_rs2 <= '0; out_rs2_en <= 1'b0; out_imm <= pick_off;
        end
        K_STORE: begin
          out_op <= '0; out_rd <= '0; out_rd_we <= 1'b0;
          out_rs1 <= cfg_base_reg; out_rs1_en <= 1'b1;
          out_rs2 <= pick_reg; out_rs2_en <= 1'b1; out_imm <= pick_off;
        end
        default: begin
          out_op <= s_op_code; out_rd <= s_rd; out_rd_we <= s_rd_we;
          out_rs1 <= s_rs1; out_rs1_en <= s_rs1_en;
          out_rs2 <= s_rs2; out_rs2_en <= s_rs2_en; out_imm <= s_imm;
        end
      endcase
    end
  end

  // R6: a stalled record keeps every field
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_rd)
      && $stable(out_rs1) && $stable(out_rs2) && $stable(out_imm) && $stable(out_op));

  // R4: the store directly follows the operation it belongs to
  a_r4_store_after_op: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_kind == K_OP && (|p_spill)
      |=> out_valid && out_kind == K_STORE);

  // R4: at most one store per instruction
  a_r4_single_store: assert property (@(posedge clk) disable iff (rst)
    $onehot0(p_spill));

  // R8: an invalid configuration yields a lone operation record
  a_r8_err_passthru: assert property (@(posedge clk) disable iff (rst)
    err_c && in_valid && in_ready |=> out_valid && out_kind == K_OP && !pend_any);

  // R2: a load never targets the base register
  a_r2_load_not_base: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind == K_LOAD |-> out_rd != cfg_base_reg);
endmodule

// File: tb/spill_fill_inserter_tb.sv
module spill_fill_inserter_tb;
  localparam int NSLOT = 3, REGW = 5, OPW = 6, IMMW = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic [REGW-1:0] cfg_base_reg;
  logic [NSLOT*REGW-1:0] cfg_slot_regs;
  logic cfg_err, in_valid, in_ready, out_valid, out_ready;
  logic [OPW-1:0] in_op, out_op;
  logic [REGW-1:0] in_rd, in_rs1, in_rs2, out_rd, out_rs1, out_rs2;
  logic in_rd_we, in_rs1_en, in_rs2_en, out_rd_we, out_rs1_en, out_rs2_en;
  logic [IMMW-1:0] in_imm, out_imm;
  logic [1:0] out_kind;

  spill_fill_inserter u_dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // captured output records
  int        n_cap;
  logic [1:0]      c_kind [8];
  logic [REGW-1:0] c_rd [8], c_rs1 [8], c_rs2 [8];
  logic [IMMW-1:0] c_imm [8];
  logic [OPW-1:0]  c_op [8];
  logic            c_rdy [8];

  task automatic set_cfg(input int b, input int s0, input int s1, input int s2);
    @(negedge clk);
    cfg_base_reg  = REGW'(b);
    cfg_slot_regs = {REGW'(s2), REGW'(s1), REGW'(s0)};
    @(negedge clk);
  endtask

  task automatic send(input int op, input int rd, input bit we, input int r1, input bit e1,
                      input int r2, input bit e2, input int imm);
    @(negedge clk);
    in_op = OPW'(op); in_rd = REGW'(rd); in_rd_we = we;
    in_rs1 = REGW'(r1); in_rs1_en = e1; in_rs2 = REGW'(r2); in_rs2_en = e2;
    in_imm = IMMW'(imm); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n_cap = 0;
    while (out_valid && n_cap < 8) begin
      c_kind[n_cap] = out_kind; c_rd[n_cap] = out_rd; c_rs1[n_cap] = out_rs1;
      c_rs2[n_cap] = out_rs2; c_imm[n_cap] = out_imm; c_op[n_cap] = out_op;
      c_rdy[n_cap] = in_ready;
      n_cap++;
      @(negedge clk);
    end
  endtask

  task automatic chk_load(input int k, input int reg_n, input int base, input int off, input string tag);
    chk(c_kind[k] == 2'd1, {tag, " kind"}, c_kind[k], 1);
    chk(c_rd[k] == REGW'(reg_n) && c_rs1[k] == REGW'(base), {tag, " regs"}, c_rd[k], reg_n);
    chk(c_imm[k] == IMMW'(off), {tag, " offset"}, c_imm[k], off);
  endtask

  task automatic chk_store(input int k, input int reg_n, input int base, input int off, input string tag);
    chk(c_kind[k] == 2'd2, {tag, " kind"}, c_kind[k], 2);
    chk(c_rs2[k] == REGW'(reg_n) && c_rs1[k] == REGW'(base), {tag, " regs"}, c_rs2[k], reg_n);
    chk(c_imm[k] == IMMW'(off), {tag, " offset"}, c_imm[k], off);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(cfg_err == 1'b0, "R1 cfg_err", cfg_err, 0);
  endtask

  task automatic t_example;
    send(7, 24, 1, 25, 1, 26, 1, 0);
    chk(n_cap == 4, "R2 count", n_cap, 4);
    chk_load(0, 25, 27, 8, "R2 fill0");
    chk_load(1, 26, 27, 12, "R2 fill1");
    chk(c_kind[2] == 2'd0 && c_op[2] == 6'd7 && c_rd[2] == 5'd24, "R3 op", c_op[2], 7);
    chk(c_rs1[2] == 5'd25 && c_rs2[2] == 5'd26, "R3 op srcs", c_rs1[2], 25);
    chk_store(3, 24, 27, 4, "R4 spill");
    chk(c_rdy[0] == 0 && c_rdy[1] == 0 && c_rdy[2] == 0, "R7 ready low", c_rdy[1], 0);
    chk(c_rdy[3] == 1'b1, "R7 ready back", c_rdy[3], 1);
  endtask

  task automatic t_plain;
    send(3, 5, 1, 6, 1, 7, 1, 123);
    chk(n_cap == 1, "R5 single", n_cap, 1);
    chk(c_kind[0] == 0 && c_imm[0] == 123 && c_rd[0] == 5, "R5 unchanged", c_imm[0], 123);
  endtask

  task automatic t_stream;
    int got = 0;
    @(negedge clk);
    in_rd_we = 1; in_rs1_en = 1; in_rs2_en = 0; in_rs1 = 2; in_rd = 3; in_valid = 1;
    for (int i = 0; i < 3; i++) begin
      in_imm = IMMW'(100 + i);
      chk(in_ready == 1'b1, "R5 ready stream", in_ready, 1);
      @(negedge clk);
      chk(out_valid && out_imm == IMMW'(100 + i), "R5 per cycle", out_imm, 100 + i);
      got++;
    end
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 drained", out_valid, 0);
  endtask

  task automatic t_same_reg;
    send(9, 25, 1, 25, 1, 25, 1, 0);
    chk(n_cap == 3, "R2 dedupe count", n_cap, 3);
    chk_load(0, 25, 27, 8, "R2 dedupe fill");
    chk(c_kind[1] == 0, "R3 op after fill", c_kind[1], 0);
    chk_store(2, 25, 27, 8, "R4 same spill");
  endtask

  task automatic t_enables;
    send(4, 25, 0, 24, 0, 26, 1, 0);
    chk(n_cap == 2, "R9 count", n_cap, 2);
    chk_load(0, 26, 27, 12, "R9 only enabled");
    chk(c_kind[1] == 0, "R9 no spill", c_kind[1], 0);
  endtask

  task automatic t_backpressure;
    logic [IMMW-1:0] first;
    @(negedge clk);
    out_ready = 0;
    in_op = 1; in_rd = 24; in_rd_we = 1; in_rs1 = 26; in_rs1_en = 1;
    in_rs2 = 25; in_rs2_en = 1; in_imm = 0; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    first = out_imm;
    chk(out_valid && out_kind == 1 && out_imm == 8, "R2 first under stall", out_imm, 8);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_kind == 1 && out_imm == first && out_rd == 25, "R6 hold", out_imm, first);
      chk(in_ready == 1'b0, "R7 stalled", in_ready, 0);
    end
    out_ready = 1;
    @(negedge clk);
    chk(out_kind == 1 && out_rd == 26 && out_imm == 12, "R2 second after release", out_rd, 26);
    @(negedge clk);
    chk(out_kind == 0, "R3 op after release", out_kind, 0);
    @(negedge clk);
    chk(out_kind == 2 && out_rs2 == 24, "R4 spill after release", out_rs2, 24);
    @(negedge clk);
    chk(out_valid == 0 && in_ready == 1, "R7 idle after", in_ready, 1);
  endtask

  task automatic t_cfg;
    set_cfg(10, 3, 4, 5);
    chk(cfg_err == 0, "R8 valid cfg", cfg_err, 0);
    send(2, 9, 1, 5, 1, 3, 1, 0);
    chk(n_cap == 3, "R2 order count", n_cap, 3);
    chk_load(0, 3, 10, 4, "R2 ascending 0");
    chk_load(1, 5, 10, 12, "R2 ascending 1");
    send(2, 3, 1, 4, 1, 0, 0, 0);
    chk(n_cap == 3, "R4 new cfg count", n_cap, 3);
    chk_store(2, 3, 10, 4, "R4 new cfg spill");
  endtask

  task automatic t_err;
    set_cfg(24, 24, 25, 26);
    chk(cfg_err == 1'b1, "R8 base clash", cfg_err, 1);
    send(7, 24, 1, 25, 1, 26, 1, 55);
    chk(n_cap == 1 && c_kind[0] == 0 && c_imm[0] == 55, "R8 passthrough", n_cap, 1);
    set_cfg(27, 24, 24, 26);
    chk(cfg_err == 1'b1, "R8 dup slots", cfg_err, 1);
    set_cfg(27, 24, 25, 26);
    chk(cfg_err == 1'b0, "R8 restored", cfg_err, 0);
  endtask

  initial begin
    cfg_base_reg = 5'd27;
    cfg_slot_regs = {5'd26, 5'd25, 5'd24};
    in_valid = 0; out_ready = 1;
    in_op = 0; in_rd = 0; in_rd_we = 0; in_rs1 = 0; in_rs1_en = 0;
    in_rs2 = 0; in_rs2_en = 0; in_imm = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_example();
    t_plain();
    t_stream();
    t_same_reg();
    t_enables();
    t_backpressure();
    t_cfg();
    t_err();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule